// File: doc/BRIEF.md
# Keyed Watchdog Timer with APB Register Access

The block is a watchdog timer that software reaches through an APB slave port. A 32-bit counter counts down from a programmable reload value while the watchdog is enabled. On the first time it runs out, the block sets an interrupt. If software has not cleared that interrupt by the following time the counter runs out, and reset generation is enabled, the block raises a reset request. Software keeps the system alive by clearing the interrupt and writing the reload register again. A write to the reload register restarts the count at once.

A key register protects the configuration. Writing the unlock key lets the other registers be written. Writing any other value to the key register blocks those writes. A test mode takes the interrupt and reset-request outputs away from the counter logic so that software can drive them directly. This makes it possible to check the board-level wiring without waiting for a timeout.

Top module: `apb_wdog_timer`

## Requirements
- R1: After reset the block is unlocked, the control register reads 0, the reload and count registers read 0xFFFFFFFF, both interrupt status registers read 0, and irq_o and rst_req_o are low.
- R2: Every transfer completes with pready high and pslverr low. Reads of unmapped offsets return 0, and reads of the write-only registers (interrupt clear at 0x00C, test output at 0xF04) return 0.
- R3: A write of 0x1ACCE551 to the key register at 0xC00 unlocks the block, and a write of any other value locks it. Reading 0xC00 returns bit 0 = 1 when locked and 0 when unlocked.
- R4: While the block is locked, writes to every register other than the key register have no effect.
- R5: A write to the reload register at 0x000 also loads the count (read at 0x004) with the written value on the same clock edge.
- R6: Control bit 0 at 0x008 lets the counter run. While it runs, the counter decrements by one each clock. On the clock after the count reaches 0, the counter reloads and the raw interrupt is set. With reload value N, the raw interrupt therefore sets N+1 clocks after counting starts. While bit 0 is 0, the count holds.
- R7: A write to 0x00C with bit 0 = 1 clears the raw interrupt. A write with bit 0 = 0 leaves it unchanged.
- R8: Raw status bit 0 at 0x010 shows the raw interrupt. Masked status bit 0 at 0x014 equals raw AND control bit 0, and it drives irq_o.
- R9: When the counter runs out while the raw interrupt is still set and control bit 1 is 1, rst_req_o goes high. It stays high until block reset.
- R10: When test-control bit 0 at 0xF00 is 1, irq_o follows bit 1 and rst_req_o follows bit 0 of the test output register at 0xF04. When test-control bit 0 is 0, both outputs return to the counter logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high (no wait states) |
| pslverr | output | 1 | Always low |
| irq_o | output | 1 | Watchdog interrupt |
| rst_req_o | output | 1 | Watchdog reset request |

## Verification
Register writes take effect on the clock edge that completes the access phase. Read data is combinational, so the bench samples it one nanosecond after the falling edge inside the access phase and matches it against the queued expected value.

After a control write, the bench counts falling edges. With reload N, irq_o must be low through edge N and high at edge N+1. The reset request must follow at edge 2N+2 and not one edge earlier. The test-mode overrides and the interrupt clear appear at the first falling edge after the write completes, and the bench checks them there.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 32;

  localparam logic [AW-1:0] OFF_RELOAD = 12'h000;
  localparam logic [AW-1:0] OFF_COUNT  = 12'h004;
  localparam logic [AW-1:0] OFF_CTRL   = 12'h008;
  localparam logic [AW-1:0] OFF_ACK    = 12'h00C;
  localparam logic [AW-1:0] OFF_RAW    = 12'h010;
  localparam logic [AW-1:0] OFF_MASKED = 12'h014;
  localparam logic [AW-1:0] OFF_KEY    = 12'hC00;
  localparam logic [AW-1:0] OFF_TCTRL  = 12'hF00;
  localparam logic [AW-1:0] OFF_TOUT   = 12'hF04;

  localparam logic [DW-1:0] OPEN_KEY   = 32'h1ACC_E551;
  localparam logic [DW-1:0] CNT_INIT   = '1;

  // next value of a running counter
  function automatic logic [DW-1:0] count_step(input logic [DW-1:0] c);
    return c - {{(DW-1){1'b0}}, 1'b1};
  endfunction

  // a key write leaves the block locked unless it carries the opening key
  function automatic logic key_locks(input logic [DW-1:0] v);
    return v != OPEN_KEY;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] reload_q,
  output logic          reload_wr,
  output logic [1:0]    ctrl_q,
  output logic          ack_wr,
  output logic          locked_q,
  output logic          tmode_q,
  output logic [1:0]    tout_q
);
  logic cfg_wr;
  assign cfg_wr    = wr_en & ~locked_q;
  assign reload_wr = cfg_wr & (addr == OFF_RELOAD);
  assign ack_wr    = cfg_wr & (addr == OFF_ACK) & wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= CNT_INIT;
      ctrl_q   <= 2'b00;
      locked_q <= 1'b0;
      tmode_q  <= 1'b0;
      tout_q   <= 2'b00;
    end else begin
      if (wr_en && addr == OFF_KEY) locked_q <= key_locks(wdata);
      if (reload_wr) reload_q <= wdata;
      if (cfg_wr && addr == OFF_CTRL)  ctrl_q  <= wdata[1:0];
      if (cfg_wr && addr == OFF_TCTRL) tmode_q <= wdata[0];
      if (cfg_wr && addr == OFF_TOUT)  tout_q  <= wdata[1:0];
    end
  end

  AST_LOCK_BLOCKS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && wr_en && addr == OFF_CTRL) |=> $stable(ctrl_q)); // R4
  AST_LOCK_BLOCKS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && wr_en && addr == OFF_RELOAD) |=> $stable(reload_q)); // R4
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] reload_q,
  input  logic          reload_wr,
  input  logic [DW-1:0] reload_wdata,
  input  logic          run,
  input  logic          rst_en,
  input  logic          ack_wr,
  output logic [DW-1:0] count_q,
  output logic          raw_q,
  output logic          rreq_q,
  output logic          expire
);
  assign expire = run & ~reload_wr & (count_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= CNT_INIT;
      raw_q   <= 1'b0;
      rreq_q  <= 1'b0;
    end else begin
      if (reload_wr)   count_q <= reload_wdata;
      else if (expire) count_q <= reload_q;
      else if (run)    count_q <= count_step(count_q);

      if (expire)      raw_q <= 1'b1;
      else if (ack_wr) raw_q <= 1'b0;

      if (expire && raw_q && rst_en) rreq_q <= 1'b1;
    end
  end

  AST_EXPIRE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count_q == $past(reload_q)) && raw_q); // R6
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reload_wr) |=> $stable(count_q)); // R6
  AST_RREQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_q |=> rreq_q); // R9
  AST_RREQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rreq_q) |-> $past(raw_q) && $past(rst_en)); // R9
endmodule

// File: rtl/apb_wdog_timer.sv
module apb_wdog_timer
  import wdog_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          pready,
  output logic          pslverr,
  output logic          irq_o,
  output logic          rst_req_o
);
  logic          wr_en;
  logic [DW-1:0] reload_q;
  logic          reload_wr;
  logic [1:0]    ctrl_q;
  logic          ack_wr;
  logic          locked_q;
  logic          tmode_q;
  logic [1:0]    tout_q;
  logic [DW-1:0] count_q;
  logic          raw_q;
  logic          rreq_q;
  logic          expire;
  logic          masked;

  assign wr_en   = psel & penable & pwrite;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign masked  = raw_q & ctrl_q[0];

  wdog_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (paddr),
    .wdata    (pwdata),
    .reload_q (reload_q),
    .reload_wr(reload_wr),
    .ctrl_q   (ctrl_q),
    .ack_wr   (ack_wr),
    .locked_q (locked_q),
    .tmode_q  (tmode_q),
    .tout_q   (tout_q)
  );

  wdog_core u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .reload_q    (reload_q),
    .reload_wr   (reload_wr),
    .reload_wdata(pwdata),
    .run         (ctrl_q[0]),
    .rst_en      (ctrl_q[1]),
    .ack_wr      (ack_wr),
    .count_q     (count_q),
    .raw_q       (raw_q),
    .rreq_q      (rreq_q),
    .expire      (expire)
  );

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (paddr)
        OFF_RELOAD: prdata = reload_q;
        OFF_COUNT:  prdata = count_q;
        OFF_CTRL:   prdata = {{(DW-2){1'b0}}, ctrl_q};
        OFF_RAW:    prdata = {{(DW-1){1'b0}}, raw_q};
        OFF_MASKED: prdata = {{(DW-1){1'b0}}, masked};
        OFF_KEY:    prdata = {{(DW-1){1'b0}}, locked_q};
        OFF_TCTRL:  prdata = {{(DW-1){1'b0}}, tmode_q};
        default:    prdata = '0;
      endcase
    end
  end

  assign irq_o     = tmode_q ? tout_q[1] : masked;
  assign rst_req_o = tmode_q ? tout_q[0] : rreq_q;

  AST_IRQ_FROM_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmode_q && irq_o) |-> raw_q); // R8
  AST_MASK_GATES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmode_q && !ctrl_q[0]) |-> !irq_o); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && (paddr == OFF_ACK || paddr == OFF_TOUT)) |-> prdata == '0); // R2
endmodule

// File: tb/sim_apb_wdog_timer.sv
`timescale 1ns/1ps
module sim_apb_wdog_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, irq_o, rst_req_o;

  int n_checks = 0;
  int n_errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  apb_wdog_timer u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // monitor: pops the scoreboard on every read access phase
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (psel && penable && !pwrite) begin
        chk("R2 pready", {31'b0, pready}, 32'd1);
        chk("R2 pslverr", {31'b0, pslverr}, 32'd0);
        if (exp_q.size() == 0) chk("scoreboard empty", 32'd1, 32'd0);
        else chk(tag_q.pop_front(), prdata, exp_q.pop_front());
      end
    end
  end

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 0);
    chk("R1 rst_req", {31'b0, rst_req_o}, 0);
    apb_rd(12'h000, 32'hFFFF_FFFF, "R1 reload");
    apb_rd(12'h004, 32'hFFFF_FFFF, "R1 count");
    apb_rd(12'h008, 0, "R1 ctrl");
    apb_rd(12'hC00, 0, "R1 key unlocked");
    apb_rd(12'h010, 0, "R1 raw");
    apb_rd(12'h014, 0, "R1 masked");
    // R2 unmapped and write-only reads
    apb_rd(12'h100, 0, "R2 unmapped");
    apb_rd(12'h00C, 0, "R2 ack reads 0");
    // R5 reload write loads count
    apb_wr(12'h000, 5);
    apb_rd(12'h004, 5, "R5 count after reload");
    apb_rd(12'h000, 5, "R5 reload");
    // R3 / R4 lock
    apb_wr(12'hC00, 32'h2BDD_F662);
    apb_rd(12'hC00, 1, "R3 locked");
    apb_wr(12'h000, 9);
    apb_wr(12'h008, 3);
    apb_wr(12'hF00, 1);
    apb_rd(12'h000, 5, "R4 reload ignored");
    apb_rd(12'h008, 0, "R4 ctrl ignored");
    apb_rd(12'hF00, 0, "R4 tctrl ignored");
    chk("R4 outputs unchanged", {30'b0, irq_o, rst_req_o}, 0);
    apb_wr(12'hC00, 32'h1ACC_E551);
    apb_rd(12'hC00, 0, "R3 unlocked");
    // R6 expiry after N+1 clocks, reset disabled
    apb_wr(12'h008, 1);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk); #1;
      chk($sformatf("R6 irq at edge %0d", k), {31'b0, irq_o}, (k == 6) ? 1 : 0);
    end
    repeat (20) @(negedge clk);
    #1 chk("R9 no request when disabled", {31'b0, rst_req_o}, 0);
    apb_rd(12'h010, 1, "R8 raw set");
    apb_rd(12'h014, 1, "R8 masked set");
    // R8 masking and R7 clear
    apb_wr(12'h008, 0);
    apb_rd(12'h010, 1, "R8 raw with run off");
    apb_rd(12'h014, 0, "R8 masked with run off");
    #1 chk("R8 irq masked", {31'b0, irq_o}, 0);
    apb_wr(12'h00C, 0);
    apb_rd(12'h010, 1, "R7 bit0=0 no clear");
    apb_wr(12'h00C, 1);
    apb_rd(12'h010, 0, "R7 cleared");
    // R9 reset request on second expiry
    apb_wr(12'h000, 3);
    apb_wr(12'h008, 3);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk); #1;
      if (k == 4) chk("R6 irq at edge 4", {31'b0, irq_o}, 1);
      if (k == 7) chk("R9 no request at edge 7", {31'b0, rst_req_o}, 0);
      if (k == 8) chk("R9 request at edge 8", {31'b0, rst_req_o}, 1);
    end
    apb_wr(12'h00C, 1);
    apb_wr(12'h008, 0);
    #1 chk("R9 request sticky", {31'b0, rst_req_o}, 1);
    do_reset();
    chk("R1 request cleared by reset", {31'b0, rst_req_o}, 0);
    // R5 feeding keeps the interrupt away
    apb_wr(12'h000, 10);
    apb_wr(12'h008, 3);
    for (int i = 0; i < 8; i++) begin
      apb_wr(12'h000, 10);
      #1 chk("R5 fed irq low", {31'b0, irq_o}, 0);
    end
    apb_rd(12'h010, 0, "R5 fed raw clear");
    apb_wr(12'h008, 0);
    // R10 test mode
    apb_wr(12'hF00, 1);
    apb_wr(12'hF04, 2);
    #1 chk("R10 irq forced", {30'b0, irq_o, rst_req_o}, 32'd2);
    apb_wr(12'hF04, 1);
    #1 chk("R10 request forced", {30'b0, irq_o, rst_req_o}, 32'd1);
    apb_rd(12'hF00, 1, "R10 tctrl read");
    apb_rd(12'hF04, 0, "R2 tout reads 0");
    apb_wr(12'hF00, 0);
    #1 chk("R10 outputs released", {30'b0, irq_o, rst_req_o}, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule